// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel with Shadowed Settings

This block drives one pulse-width-modulated output. Its period comes from a phase accumulator `STEP_W` bits wide that advances by a programmable step on every clock. The output frequency is therefore the clock frequency times the step, divided by 2^`STEP_W`. The duty cycle is set by an 8-bit threshold held in inverted form: the output is high while the upper eight accumulator bits are at or above the threshold. A threshold of 0 gives the widest pulse and 255 the narrowest.

Software reaches the block through one 32-bit control word on a plain write strobe and a continuously driven read word. Settings are first written to a shadow copy. They move to the active copy only when software raises the update-request bit, and then only at the clock where the accumulator wraps, which is where a new output period begins. The update-request bit reads back as set until that handover. Software polls it before sending another configuration, because a configuration that arrives while the bit is still set is dropped. Only its enable bit is kept.

Top module: `pwm_phase_ch`

## Requirements
- R1: The control word has enable at bit 31, update-pending at bit 30, the step in bits [8+STEP_W-1:8] and the threshold in bits [7:0]. Reading returns enable, pending, the shadow step and the shadow threshold in those positions, with every other bit 0.
- R2: After reset the read word is all zeros and the output is low. Both the shadow and the active step and threshold are zero.
- R3: While the active step is zero, the accumulator does not advance and the output stays low.
- R4: While enabled, the accumulator adds the active step modulo 2^STEP_W on every clock, so one output period lasts 2^STEP_W/step clocks.
- R5: While enabled with a nonzero step, the output is high exactly when the upper 8 accumulator bits are greater than or equal to the active threshold. Threshold 0 keeps it high throughout.
- R6: A write with bit 30 set, made while no update is pending, loads the shadow fields and sets pending. In the clock where the accumulator wraps, the shadow values become active and pending clears.
- R7: A write made while pending is set leaves the shadow step, the shadow threshold and pending unchanged. Its enable bit still takes effect.
- R8: While disabled, the output is low and the accumulator is held at zero. A pending update commits on the first clock that sees the channel disabled.
- R9: While the active step is zero, a pending update commits on the next clock.
- R10: A write with bit 30 clear, made while no update is pending, changes the shadow fields and the enable bit only. The active step and threshold are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word readback |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded assertions check the rules that must hold on every cycle. A write during pending leaves the shadow fields and the pending flag alone. Pending drops in the clock after a wrap. The accumulator stays at zero while disabled and does not move while the step is zero. The output stays low while disabled. Only the directed scenarios can show the quantities that span many cycles: high-time counts and period counts for several step and threshold pairs. They also show how long pending waits for a wrap, that a dropped write leaves no trace once the handover completes, and that a shadow-only write leaves the running duty cycle unchanged.

// File: rtl/pwm_pch_pkg.sv
package pwm_pch_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned EN_BIT   = 31;
   localparam int unsigned UPD_BIT  = 30;
   localparam int unsigned STEP_LSB = 8;
   localparam int unsigned THR_W    = 8;

   typedef enum logic [1:0] {
      CMT_NONE  = 2'd0,
      CMT_WRAP  = 2'd1,
      CMT_IDLE  = 2'd2,
      CMT_STALL = 2'd3
   } commit_cause_e;
endpackage

// File: rtl/pwm_pch_ctrl.sv
module pwm_pch_ctrl
   import pwm_pch_pkg::*;
#(
   parameter int unsigned STEP_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                commit_i,
   output logic                en_o,
   output logic                pend_o,
   output logic [STEP_W-1:0]   act_step_o,
   output logic [THR_W-1:0]    act_thr_o,
   output logic [WORD_W-1:0]   rd_data_o
);
   logic [STEP_W-1:0] sh_step_q;
   logic [THR_W-1:0]  sh_thr_q;
   logic [STEP_W-1:0] act_step_q;
   logic [THR_W-1:0]  act_thr_q;
   logic              en_q;
   logic              pend_q;
   logic              fields_open;

   assign fields_open = wr_en && !pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         pend_q    <= 1'b0;
         sh_step_q <= '0;
         sh_thr_q  <= '0;
      end else begin
         if (wr_en) en_q <= wr_data[EN_BIT];
         if (fields_open) begin
            sh_step_q <= wr_data[STEP_LSB +: STEP_W];
            sh_thr_q  <= wr_data[THR_W-1:0];
            pend_q    <= wr_data[UPD_BIT];
         end else if (commit_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_step_q <= '0;
         act_thr_q  <= '0;
      end else if (commit_i && pend_q) begin
         act_step_q <= sh_step_q;
         act_thr_q  <= sh_thr_q;
      end
   end

   always_comb begin
      rd_data_o                      = '0;
      rd_data_o[EN_BIT]              = en_q;
      rd_data_o[UPD_BIT]             = pend_q;
      rd_data_o[STEP_LSB +: STEP_W]  = sh_step_q;
      rd_data_o[THR_W-1:0]           = sh_thr_q;
   end

   assign en_o       = en_q;
   assign pend_o     = pend_q;
   assign act_step_o = act_step_q;
   assign act_thr_o  = act_thr_q;

   // R7: a write during pending leaves the shadow and pending untouched
   a_r7_pending_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pend_q && !commit_i) |=> ($stable(sh_step_q) && $stable(sh_thr_q) && pend_q));

   // R6: the active copy only moves on a commit of a pending update
   a_r6_active_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_i && pend_q) |=> ($stable(act_step_q) && $stable(act_thr_q)));
endmodule

// File: rtl/pwm_pch_accum.sv
module pwm_pch_accum #(
   parameter int unsigned STEP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [STEP_W-1:0] phase_o,
   output logic              wrap_o
);
   logic [STEP_W-1:0] phase_q;
   logic [STEP_W:0]   sum;

   assign sum    = {1'b0, phase_q} + {1'b0, step_i};
   assign wrap_o = en_i && sum[STEP_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase_q <= '0;
      else if (!en_i) phase_q <= '0;
      else            phase_q <= sum[STEP_W-1:0];
   end

   assign phase_o = phase_q;

   // R8: accumulator held at zero while disabled
   a_r8_phase_zero_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (phase_q == '0));

   // R3: a zero step never advances the accumulator
   a_r3_zero_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && step_i == '0) |=> $stable(phase_q));
endmodule

// File: rtl/pwm_pch_duty.sv
module pwm_pch_duty #(
   parameter int unsigned STEP_W  = 16,
   parameter int unsigned THR_W   = 8,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              step_zero_i,
   input  logic [STEP_W-1:0] phase_i,
   input  logic [THR_W-1:0]  thr_i,
   output logic              out_o
);
   logic [THR_W-1:0] top_bits;
   logic             high_raw;

   assign top_bits = phase_i[STEP_W-1 -: THR_W];
   assign high_raw = en_i && !step_zero_i && (top_bits >= thr_i);

   generate
      if (OUT_REG) begin : g_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= high_raw;
         end
         assign out_o = out_q;
      end else begin : g_comb
         assign out_o = high_raw;
      end
   endgenerate

   // R8: output low while disabled
   a_r8_out_low_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!en_i) && !en_i) |-> !out_o);
endmodule

// File: rtl/pwm_phase_ch.sv
module pwm_phase_ch
   import pwm_pch_pkg::*;
#(
   parameter int unsigned STEP_W  = 16,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic        pwm_out
);
   localparam int unsigned FIELD_TOP = STEP_LSB + STEP_W;

   generate
      if (STEP_W != 16 && STEP_W != 22) begin : g_bad_width
         $error("pwm_phase_ch: STEP_W must be 16 or 22");
      end
      if (FIELD_TOP > UPD_BIT) begin : g_bad_layout
         $error("pwm_phase_ch: step field overlaps the flag bits");
      end
   endgenerate

   logic              en;
   logic              pend;
   logic [STEP_W-1:0] act_step;
   logic [THR_W-1:0]  act_thr;
   logic [STEP_W-1:0] phase;
   logic              wrap;
   logic              step_zero;
   logic              commit;
   commit_cause_e     cause;

   assign step_zero = (act_step == '0);

   always_comb begin
      if (!pend)          cause = CMT_NONE;
      else if (!en)       cause = CMT_IDLE;
      else if (step_zero) cause = CMT_STALL;
      else if (wrap)      cause = CMT_WRAP;
      else                cause = CMT_NONE;
   end
   assign commit = (cause != CMT_NONE);

   pwm_pch_ctrl #(.STEP_W(STEP_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .commit_i   (commit),
      .en_o       (en),
      .pend_o     (pend),
      .act_step_o (act_step),
      .act_thr_o  (act_thr),
      .rd_data_o  (rd_data)
   );

   pwm_pch_accum #(.STEP_W(STEP_W)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en),
      .step_i  (act_step),
      .phase_o (phase),
      .wrap_o  (wrap)
   );

   pwm_pch_duty #(.STEP_W(STEP_W), .THR_W(THR_W), .OUT_REG(OUT_REG)) u_duty (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en),
      .step_zero_i (step_zero),
      .phase_i     (phase),
      .thr_i       (act_thr),
      .out_o       (pwm_out)
   );

   // R6: pending clears in the clock after a wrap that finds it set
   a_r6_wrap_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && wrap && !wr_en) |=> !pend);

   // R8: a pending update never survives a disabled clock
   a_r8_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !en && !wr_en) |=> !pend);

   // R9: a zero active step cannot hold an update pending
   a_r9_stall_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && en && step_zero && !wr_en) |=> !pend);
endmodule

// File: tb/sim_pwm_phase_ch.sv
module sim_pwm_phase_ch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pwm_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwm_phase_ch #(.STEP_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pwm_out(pwm_out)
   );

   function automatic logic [31:0] word(input bit en, input bit upd,
                                        input logic [15:0] step, input logic [7:0] thr);
      return {en, upd, 6'b0, step, thr};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(input int n, output int highs, output int rises);
      logic prev;
      highs = 0; rises = 0; prev = pwm_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
         if (pwm_out && !prev) rises++;
         prev = pwm_out;
      end
   endtask

   task automatic t_reset();
      check("R2 readback", rd_data, 32'h0);
      check("R2 output", {31'b0, pwm_out}, 32'h0);
   endtask

   task automatic t_program_disabled();
      wr(word(0, 1, 16'h4000, 8'h80));
      check("R1 R6 pending set", rd_data, word(0, 1, 16'h4000, 8'h80));
      @(negedge clk);
      check("R8 idle commit", rd_data, word(0, 0, 16'h4000, 8'h80));
   endtask

   task automatic t_duty_basic();
      int h, r;
      wr(word(1, 0, 16'h4000, 8'h80));
      measure(64, h, r);
      check("R5 half duty highs", h, 32);
      check("R4 period 4 rises", r, 16);
   endtask

   task automatic t_shadow_only();
      int h, r;
      wr(word(1, 0, 16'h4000, 8'h00));
      check("R10 shadow readback", rd_data, word(1, 0, 16'h4000, 8'h00));
      measure(64, h, r);
      check("R10 active unchanged", h, 32);
   endtask

   task automatic t_wrap_commit();
      int h, r, waited;
      wr(word(1, 1, 16'h1000, 8'h80));
      waited = 0;
      while (rd_data[30] && waited < 40) begin @(negedge clk); waited++; end
      check("R6 first commit", rd_data, word(1, 0, 16'h1000, 8'h80));
      wr(word(1, 1, 16'h2000, 8'h40));
      check("R6 pending after write", {31'b0, rd_data[30]}, 32'h1);
      wr(word(1, 1, 16'h4000, 8'h10));
      waited = 2;
      while (rd_data[30] && waited < 40) begin @(negedge clk); waited++; end
      check("R6 wait within one period", {31'b0, waited <= 17}, 32'h1);
      check("R7 dropped write", rd_data, word(1, 0, 16'h2000, 8'h40));
      measure(64, h, r);
      check("R5 three quarter duty", h, 48);
      check("R4 period 8 rises", r, 8);
   endtask

   task automatic t_disable_pending();
      int h, r, waited;
      wr(word(1, 1, 16'h0001, 8'hFF));
      waited = 0;
      while (rd_data[30] && waited < 40) begin @(negedge clk); waited++; end
      check("R6 slow step active", rd_data, word(1, 0, 16'h0001, 8'hFF));
      wr(word(1, 1, 16'h4000, 8'h80));
      repeat (10) @(negedge clk);
      check("R6 held without wrap", {31'b0, rd_data[30]}, 32'h1);
      wr(word(0, 0, 16'h1234, 8'h55));
      check("R7 enable honoured", {31'b0, rd_data[31]}, 32'h0);
      @(negedge clk);
      check("R8 disable commits", rd_data, word(0, 0, 16'h4000, 8'h80));
      measure(16, h, r);
      check("R8 output low disabled", h, 0);
   endtask

   task automatic t_zero_step();
      int h, r;
      wr(word(0, 1, 16'h0000, 8'h00));
      @(negedge clk);
      wr(word(1, 0, 16'h0000, 8'h00));
      measure(32, h, r);
      check("R3 zero step low", h, 0);
      wr(word(1, 1, 16'h2000, 8'hFF));
      check("R9 pending seen", {31'b0, rd_data[30]}, 32'h1);
      @(negedge clk);
      check("R9 stall commit", rd_data, word(1, 0, 16'h2000, 8'hFF));
      measure(64, h, r);
      check("R5 threshold 255 never high", h, 0);
      wr(word(1, 0, 16'h2000, 8'h00));
      wr(word(1, 1, 16'h2000, 8'h00));
      repeat (10) @(negedge clk);
      measure(64, h, r);
      check("R5 threshold 0 always high", h, 64);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program_disabled();
      t_duty_basic();
      t_shadow_only();
      t_wrap_commit();
      t_disable_pending();
      t_zero_step();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule